// File: doc/BRIEF.md
# Transmit Length Accounting Queue

This block keeps the books for outbound buffers that a card-side controller has lined up for a host to read. Each buffer is loaded as a byte length plus an opaque tag, and occupies exactly one slot in a queue of parameterised depth. The block reports how many bytes the host may fetch next. It raises a level interrupt request while that figure is non-zero, and it accepts a per-cycle count of bytes that the host has actually taken. The data itself never passes through the block.

Two accounting modes are selected by a single input. In stream mode every accepted buffer adds to the readable total at once, so one host read may run across several queued buffers. In packet mode only the oldest buffer is exposed, and the next one appears only after the oldest has been drained and released. Drained buffers are handed back to the loading side strictly in load order, one per cycle, each with its tag, so that their storage can be reused.

Top module: `sdtq_txlen_queue`

## Requirements
- R1: While reset is held and on the first cycle after it, `avail_len` is 0, `host_irq` is 0 and `done_valid` is 0.
- R2: A load with `ld_valid` high, a length from 1 to 4092 and fewer than DEPTH entries held is accepted in that cycle, takes one entry and holds its tag. Exactly DEPTH such loads fill the queue.
- R3: A load is refused with `ld_reject` high in the same cycle, and changes no state, when the queue holds DEPTH entries (even if an entry is released in that cycle) or when the length is 0 or greater than 4092.
- R4: With `mode_pkt` = 0 (stream), `avail_len` equals the sum of the lengths of all held entries minus the bytes taken against them. A load shows up in the cycle after its clock edge, even while older entries are unread.
- R5: In stream mode a single take may consume bytes from several consecutive entries. The entries it empties are released one per cycle, starting in the cycle after the take.
- R6: With `mode_pkt` = 1 (packet), `avail_len` is the untaken remainder of the oldest entry only, and 0 once that entry is fully taken. The next entry's length appears in the cycle after the oldest is released.
- R7: A take with `take_valid` high consumes the smaller of `take_bytes` and the current `avail_len`, and any excess is discarded.
- R8: `done_valid` is high, with `done_tag` equal to the oldest entry's tag, exactly when every byte of that entry has been taken. The entry is freed at that clock edge, and completions follow load order.
- R9: `host_irq` is high exactly when `avail_len` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pkt | input | 1 | 0 = stream accounting, 1 = packet accounting |
| ld_valid | input | 1 | Load request for one buffer |
| ld_len | input | LEN_W | Buffer length in bytes |
| ld_tag | input | TAG_W | Tag returned on completion |
| ld_reject | output | 1 | Load refused in this cycle |
| take_valid | input | 1 | Host consumed bytes this cycle |
| take_bytes | input | SUM_W | Number of bytes consumed |
| avail_len | output | SUM_W | Bytes the host may read next |
| host_irq | output | 1 | Data-ready interrupt request (level) |
| done_valid | output | 1 | Oldest entry fully consumed and released at this edge |
| done_tag | output | TAG_W | Tag of the released entry |

## Verification
`ld_reject` is a same-cycle function of the request and the held entry count. `avail_len` and `host_irq` reflect a load or take made at edge k from just after edge k. `done_valid` for an entry whose last byte was taken at edge k rises just after edge k and drops after edge k+1, when the entry is freed. In packet mode the next entry's length therefore appears one cycle after the final take. The bench drives inputs at the falling edge, evaluates its reference model for the state produced by the previous rising edge, and samples every output one nanosecond later, before the next rising edge. This lets both the same-cycle outputs and the one-edge results be compared in the cycle where they are due.

// File: rtl/sdtq_pkg.sv
package sdtq_pkg;
  typedef enum logic {
    ACCT_STREAM = 1'b0,
    ACCT_PACKET = 1'b1
  } acct_mode_e;
endpackage

// File: rtl/sdtq_fifo.sv
module sdtq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // slot storage: one enabled register bank per entry, no reset
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[i] <= din;
    end
  end

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = slot_q[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/sdtq_meter.sv
module sdtq_meter
  import sdtq_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acct_mode_e       mode,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             nonempty,
  input  logic [LEN_W-1:0] head_len,
  input  logic             take_valid,
  input  logic [SUM_W-1:0] take_bytes,
  output logic [SUM_W-1:0] avail,
  output logic             retire
);
  logic [SUM_W-1:0] total_q, total_d;
  logic [SUM_W-1:0] credit_q, credit_d;
  logic [SUM_W-1:0] head_w, add_w, sub_w, take_eff;
  logic [SUM_W-1:0] pkt_avail, str_avail;

  always_comb begin
    head_w    = SUM_W'(head_len);
    retire    = nonempty && (credit_q >= head_w);
    str_avail = total_q - credit_q;
    pkt_avail = (!nonempty || retire) ? '0 : head_w - credit_q;
    avail     = (mode == ACCT_PACKET) ? pkt_avail : str_avail;
    take_eff  = '0;
    if (take_valid) take_eff = (take_bytes > avail) ? avail : take_bytes;
    add_w     = push ? SUM_W'(push_len) : '0;
    sub_w     = retire ? head_w : '0;
    total_d   = total_q + add_w - sub_w;
    credit_d  = credit_q + take_eff - sub_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q  <= '0;
      credit_q <= '0;
    end else begin
      total_q  <= total_d;
      credit_q <= credit_d;
    end
  end
endmodule

// File: rtl/sdtq_txlen_queue.sv
module sdtq_txlen_queue
  import sdtq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LEN_W   = 12,
  parameter int TAG_W   = 8,
  parameter int MAX_LEN = 4092,
  localparam int CNT_W  = $clog2(DEPTH+1),
  localparam int SUM_W  = LEN_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_pkt,
  input  logic             ld_valid,
  input  logic [LEN_W-1:0] ld_len,
  input  logic [TAG_W-1:0] ld_tag,
  output logic             ld_reject,
  input  logic             take_valid,
  input  logic [SUM_W-1:0] take_bytes,
  output logic [SUM_W-1:0] avail_len,
  output logic             host_irq,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag
);
  localparam int ENT_W = LEN_W + TAG_W;

  logic [CNT_W-1:0] occ;
  logic [ENT_W-1:0] head_ent;
  logic             q_full, len_bad, accept, retire;

  assign q_full    = (occ == CNT_W'(DEPTH));
  assign len_bad   = (ld_len == '0) || (ld_len > LEN_W'(MAX_LEN));
  assign ld_reject = ld_valid && (q_full || len_bad);
  assign accept    = ld_valid && !ld_reject;

  sdtq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .pop   (retire),
    .din   ({ld_tag, ld_len}),
    .head  (head_ent),
    .count (occ)
  );

  sdtq_meter #(.LEN_W(LEN_W), .SUM_W(SUM_W)) i_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (acct_mode_e'(mode_pkt)),
    .push       (accept),
    .push_len   (ld_len),
    .nonempty   (occ != '0),
    .head_len   (head_ent[LEN_W-1:0]),
    .take_valid (take_valid),
    .take_bytes (take_bytes),
    .avail      (avail_len),
    .retire     (retire)
  );

  assign host_irq   = (avail_len != '0);
  assign done_valid = retire;
  assign done_tag   = head_ent[ENT_W-1:LEN_W];
endmodule

// File: rtl/sdtq_txlen_chk.sv
module sdtq_txlen_chk #(
  parameter int DEPTH   = 8,
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 4092,
  parameter int CNT_W   = 4,
  parameter int SUM_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_pkt,
  input logic             ld_valid,
  input logic [LEN_W-1:0] ld_len,
  input logic             ld_reject,
  input logic             take_valid,
  input logic [SUM_W-1:0] avail_len,
  input logic             host_irq,
  input logic             done_valid,
  input logic [CNT_W-1:0] occ
);
  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && occ == CNT_W'(DEPTH)) |-> ld_reject);

  // R3
  refuse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_reject && !done_valid) |=> (occ == $past(occ)));

  // R8
  done_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (occ != '0));

  // R9
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !host_irq);

  // R6
  pkt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pkt |-> (avail_len <= SUM_W'(MAX_LEN)));

  // R4
  stream_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pkt && ld_valid && !ld_reject && !take_valid && !done_valid)
    |=> (mode_pkt || avail_len == $past(avail_len) + SUM_W'($past(ld_len))));
endmodule

bind sdtq_txlen_queue sdtq_txlen_chk #(
  .DEPTH(DEPTH), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .SUM_W(SUM_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_pkt   (mode_pkt),
  .ld_valid   (ld_valid),
  .ld_len     (ld_len),
  .ld_reject  (ld_reject),
  .take_valid (take_valid),
  .avail_len  (avail_len),
  .host_irq   (host_irq),
  .done_valid (done_valid),
  .occ        (occ)
);

// File: tb/test_sdtq_txlen_queue.sv
module test_sdtq_txlen_queue;
  localparam int DEPTH = 8;
  localparam int LEN_W = 12;
  localparam int TAG_W = 8;
  localparam int SUM_W = LEN_W + $clog2(DEPTH+1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mode_pkt;
  logic             ld_valid;
  logic [LEN_W-1:0] ld_len;
  logic [TAG_W-1:0] ld_tag;
  logic             ld_reject;
  logic             take_valid;
  logic [SUM_W-1:0] take_bytes;
  logic [SUM_W-1:0] avail_len;
  logic             host_irq;
  logic             done_valid;
  logic [TAG_W-1:0] done_tag;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  // reference model state
  int m_len [DEPTH];
  int m_tag [DEPTH];
  int m_head = 0;
  int m_cnt  = 0;
  int m_tot  = 0;
  int m_cred = 0;

  always #2 clk = ~clk;

  sdtq_txlen_queue #(.DEPTH(DEPTH), .LEN_W(LEN_W), .TAG_W(TAG_W)) i_sdtq_txlen_queue (
    .clk(clk), .rst_n(rst_n), .mode_pkt(mode_pkt), .ld_valid(ld_valid),
    .ld_len(ld_len), .ld_tag(ld_tag), .ld_reject(ld_reject),
    .take_valid(take_valid), .take_bytes(take_bytes), .avail_len(avail_len),
    .host_irq(host_irq), .done_valid(done_valid), .done_tag(done_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_avail(input bit pkt);
    if (!pkt) return m_tot - m_cred;
    if (m_cnt == 0 || m_cred >= m_len[m_head]) return 0;
    return m_len[m_head] - m_cred;
  endfunction

  function automatic bit exp_retire();
    return (m_cnt > 0) && (m_cred >= m_len[m_head]);
  endfunction

  // one cycle: drive at falling edge, check outputs, advance model
  task automatic cyc(input bit pkt, input bit lv, input int len, input int tag,
                     input bit tv, input int tb, input string rq);
    int  av;
    bit  rt;
    bit  rj;
    int  te;
    @(negedge clk);
    mode_pkt   = pkt;
    ld_valid   = lv;
    ld_len     = LEN_W'(len);
    ld_tag     = TAG_W'(tag);
    take_valid = tv;
    take_bytes = SUM_W'(tb);
    #1;
    av = exp_avail(pkt);
    rt = exp_retire();
    rj = lv && (m_cnt == DEPTH || len == 0 || len > 4092);
    chk(int'(avail_len) == av, rq, "avail_len", int'(avail_len), av);
    chk(host_irq == (av != 0), "R9", "host_irq", int'(host_irq), int'(av != 0));
    chk(done_valid == rt, "R8", "done_valid", int'(done_valid), int'(rt));
    if (rt) chk(int'(done_tag) == m_tag[m_head], "R8", "done_tag",
                int'(done_tag), m_tag[m_head]);
    chk(ld_reject == rj, rj ? "R3" : "R2", "ld_reject", int'(ld_reject), int'(rj));
    te = tv ? ((tb > av) ? av : tb) : 0;
    m_cred += te;
    if (lv && !rj) begin
      m_len[(m_head + m_cnt) % DEPTH] = len;
      m_tag[(m_head + m_cnt) % DEPTH] = tag;
      m_tot += len;
    end
    if (rt) begin
      m_cred -= m_len[m_head];
      m_tot  -= m_len[m_head];
      m_head  = (m_head + 1) % DEPTH;
      m_cnt--;
    end
    if (lv && !rj) m_cnt++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_pkt = 1'b0; ld_valid = 1'b0; ld_len = '0; ld_tag = '0;
    take_valid = 1'b0; take_bytes = '0;
    void'($urandom(32'd20240611));
    #1;
    chk(avail_len == '0, "R1", "avail_len in reset", int'(avail_len), 0);
    chk(host_irq == 1'b0, "R1", "host_irq in reset", int'(host_irq), 0);
    chk(done_valid == 1'b0, "R1", "done_valid in reset", int'(done_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R1");

    // R2: fill to DEPTH, stream sums grow immediately (R4)
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 100 + i, 16 + i, 0, 0, "R4");
    // R3: full queue refuses, state unchanged
    cyc(0, 1, 50, 99, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R3");
    // R5: one take spanning three entries (100+101+102 = 303)
    cyc(0, 0, 0, 0, 1, 303, "R5");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R5");
    // R7: oversize take clamps to what is available
    cyc(0, 0, 0, 0, 1, 30000, "R7");
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 0, "R7");
    // R3: illegal lengths
    cyc(0, 1, 0, 1, 0, 0, "R3");
    cyc(0, 1, 4093, 2, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, "R3");
    // R2 boundary 4092 and R6 packet exposure
    cyc(1, 1, 4092, 40, 0, 0, "R6");
    cyc(1, 1, 7, 41, 0, 0, "R6");
    cyc(1, 0, 0, 0, 1, 4000, "R6");
    cyc(1, 0, 0, 0, 1, 92, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 1, 7, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");

    // random phase
    begin
      bit pk = 0;
      for (int n = 0; n < 5000; n++) begin
        int r, len, tb;
        bit lv, tv;
        if (($urandom % 300) == 0) pk = ~pk;
        r   = $urandom % 100;
        len = (r < 3) ? 0 : (r < 6) ? 4093 : (r < 10) ? 4092 : 1 + ($urandom % 600);
        lv  = ($urandom % 3) == 0;
        tv  = ($urandom % 2) == 0;
        tb  = $urandom % 1500;
        cyc(pk, lv, len, $urandom % 256, tv, tb, pk ? "R6" : "R4");
      end
    end

    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule